// File: doc/BRIEF.md
# Self-ID Receive Status Tracker

This block follows the self-identification quadlets that arrive after each serial bus reset and turns each one into a write request into a host memory buffer. Software programs a buffer base through a pointer register whose low address bits are forced to zero, so the buffer always starts on an aligned boundary. Every accepted quadlet goes to the next quadlet slot of that buffer.

Alongside the writes, the block keeps a read-only status word. The word holds a wrapping count of bus resets, the number of quadlets stored for the current reset generation, and an error flag. The flag is raised by a receive error or a host write error and stays raised until a later reception ends cleanly. Decoding of the physical-layer packets and the real memory bus protocol sit outside the block; here they are reduced to strobes.

Top module: `sid_tracker`

## Requirements
- R1: After reset the pointer register reads 0, the status word reads 0 and no memory write is requested.
- R2: A register write with `regWrSel`=0 loads the pointer register with `regWrData`, with bits `ALIGN_LSB-1:0` forced to zero (the default `ALIGN_LSB`=11 gives 2 KB alignment).
- R3: The status word holds the error flag in bit 31, the generation count in bits 23:16 and the quadlet count in bits 12:2; every other bit reads zero.
- R4: A `qValid` pulse that is accepted produces, one cycle later, `memWrEn`=1 with `memWrAddr` = pointer + 4 × (quadlet count before the pulse) and `memWrData` = `qData`; the quadlet count then rises by one.
- R5: Each `busReset` pulse raises the generation count by one, and it wraps from 255 to 0.
- R6: A `busReset` pulse sets the quadlet count to zero; a `qValid` pulse in the same cycle is dropped, with no memory write.
- R7: The quadlet count stops at 2^(`ALIGN_LSB`-2), the number of quadlets in one buffer; once that value is reached, further `qValid` pulses are dropped with no memory write.
- R8: A `rxError` or `hostWrErr` pulse sets the error flag, visible in the next cycle.
- R9: The error flag is cleared by an `rxDone` pulse only if no error pulse has arrived since the last `busReset` or `rxDone`; an `rxDone` that ends an erroneous reception leaves the flag set.
- R10: A register write with `regWrSel`=1 (status word) changes neither the status word nor the pointer register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReset | input | 1 | One-cycle pulse: a bus reset was detected |
| qValid | input | 1 | One-cycle strobe: `qData` holds a received self-ID quadlet |
| qData | input | 32 | Received quadlet |
| rxError | input | 1 | Pulse: hardware receive error |
| rxDone | input | 1 | Pulse: current reception finished |
| hostWrErr | input | 1 | Pulse: host bus write error |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 1 | Register select: 0 pointer, 1 status word |
| regWrData | input | 32 | Register write data |
| ptrReg | output | 32 | Buffer pointer register |
| statusReg | output | 32 | Status word |
| memWrEn | output | 1 | Memory write request |
| memWrAddr | output | 32 | Memory write byte address |
| memWrData | output | 32 | Memory write data |

## Verification
The bench builds the block with `ALIGN_LSB`=6, which makes the buffer 64 bytes, or 16 quadlets. With that size the saturation limit and the dropped writes beyond it are reached in a few dozen cycles, and the masking of six low pointer bits stays visible in the readback. The 256 resets needed to see the generation count wrap do not depend on this parameter, and the bench runs them in full.

// File: rtl/sid_pkg.sv
`timescale 1ns/1ps
package sid_pkg;
  localparam int CNT_W   = 11;
  localparam int GEN_W   = 8;
  localparam int ERR_BIT = 31;
  localparam int GEN_LSB = 16;
  localparam int CNT_LSB = 2;

  typedef enum logic {
    REG_PTR  = 1'b0,
    REG_STAT = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic acceptQ;
    logic clrCount;
    logic bumpGen;
    logic setErr;
    logic clrErr;
    logic loadPtr;
  } ctrl_t;
endpackage

// File: rtl/sid_ctrl.sv
`timescale 1ns/1ps
module sid_ctrl #(
  parameter int ALIGN_LSB = 11
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busReset,
  input  logic                     qValid,
  input  logic                     rxError,
  input  logic                     rxDone,
  input  logic                     hostWrErr,
  input  logic                     regWrEn,
  input  logic                     regWrSel,
  input  logic [sid_pkg::CNT_W-1:0] count,
  output sid_pkg::ctrl_t           strb
);
  import sid_pkg::*;

  localparam int MAXQ = 1 << (ALIGN_LSB - 2);
  localparam logic [CNT_W-1:0] MAXQ_C = CNT_W'(MAXQ);

  logic pendErr;
  logic anyErr;

  assign anyErr = rxError | hostWrErr;

  always_comb begin
    strb          = '0;
    strb.clrCount = busReset;
    strb.bumpGen  = busReset;
    strb.acceptQ  = qValid && !busReset && (count < MAXQ_C);
    strb.setErr   = anyErr;
    strb.clrErr   = rxDone && !pendErr && !anyErr;
    strb.loadPtr  = regWrEn && (reg_sel_e'(regWrSel) == REG_PTR);
  end

  // Tracks whether the reception in progress has seen any error.
  always_ff @(posedge clk) begin
    if (!rstN)                   pendErr <= 1'b0;
    else if (anyErr)             pendErr <= 1'b1;
    else if (busReset || rxDone) pendErr <= 1'b0;
  end
endmodule

// File: rtl/sid_datapath.sv
`timescale 1ns/1ps
module sid_datapath #(
  parameter int ALIGN_LSB = 11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sid_pkg::ctrl_t            strb,
  input  logic [31:0]               qData,
  input  logic [31:0]               regWrData,
  output logic [sid_pkg::CNT_W-1:0] count,
  output logic [31:0]               ptrReg,
  output logic [31:0]               statusReg,
  output logic                      memWrEn,
  output logic [31:0]               memWrAddr,
  output logic [31:0]               memWrData
);
  import sid_pkg::*;

  localparam logic [31:0] PTR_MASK = ~((32'd1 << ALIGN_LSB) - 32'd1);

  logic [GEN_W-1:0] gen;
  logic             errFlag;
  logic [31:0]      slotOffset;

  assign slotOffset = 32'(count) << 2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg    <= '0;
      count     <= '0;
      gen       <= '0;
      errFlag   <= 1'b0;
      memWrEn   <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
    end else begin
      if (strb.loadPtr) ptrReg <= regWrData & PTR_MASK;

      memWrEn <= strb.acceptQ;
      if (strb.acceptQ) begin
        memWrAddr <= ptrReg | slotOffset;
        memWrData <= qData;
      end

      if (strb.clrCount)     count <= '0;
      else if (strb.acceptQ) count <= count + 1'b1;

      if (strb.bumpGen) gen <= gen + 1'b1;

      if (strb.setErr)      errFlag <= 1'b1;
      else if (strb.clrErr) errFlag <= 1'b0;
    end
  end

  always_comb begin
    statusReg                          = '0;
    statusReg[ERR_BIT]                 = errFlag;
    statusReg[GEN_LSB+GEN_W-1:GEN_LSB] = gen;
    statusReg[CNT_LSB+CNT_W-1:CNT_LSB] = count;
  end
endmodule

// File: rtl/sid_tracker.sv
`timescale 1ns/1ps
module sid_tracker #(
  parameter int ALIGN_LSB = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReset,
  input  logic        qValid,
  input  logic [31:0] qData,
  input  logic        rxError,
  input  logic        rxDone,
  input  logic        hostWrErr,
  input  logic        regWrEn,
  input  logic        regWrSel,
  input  logic [31:0] regWrData,
  output logic [31:0] ptrReg,
  output logic [31:0] statusReg,
  output logic        memWrEn,
  output logic [31:0] memWrAddr,
  output logic [31:0] memWrData
);
  sid_pkg::ctrl_t              strb;
  logic [sid_pkg::CNT_W-1:0]   count;

  sid_ctrl #(.ALIGN_LSB(ALIGN_LSB)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .qValid(qValid),
    .rxError(rxError), .rxDone(rxDone), .hostWrErr(hostWrErr),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .count(count), .strb(strb)
  );

  sid_datapath #(.ALIGN_LSB(ALIGN_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .qData(qData),
    .regWrData(regWrData), .count(count), .ptrReg(ptrReg),
    .statusReg(statusReg), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData)
  );
endmodule

// File: rtl/sid_tracker_chk.sv
`timescale 1ns/1ps
module sid_tracker_chk #(
  parameter int ALIGN_LSB = 11
) (
  input logic        clk,
  input logic        rstN,
  input logic        busReset,
  input logic        rxError,
  input logic        hostWrErr,
  input logic [31:0] ptrReg,
  input logic [31:0] statusReg,
  input logic        memWrEn,
  input logic [31:0] memWrAddr
);
  localparam int MAXQ = 1 << (ALIGN_LSB - 2);
  localparam logic [31:0] LOW_MASK = (32'd1 << ALIGN_LSB) - 32'd1;

  assert_ptr_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ptrReg & LOW_MASK) == 32'd0);

  assert_reserved_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg & 32'h7F00_E003) == 32'd0);

  assert_addr_in_buf_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ((memWrAddr & ~LOW_MASK) == ($past(ptrReg) & ~LOW_MASK))
                && (memWrAddr[1:0] == 2'b00));

  assert_gen_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> statusReg[23:16] == 8'($past(statusReg[23:16]) + 8'd1));

  assert_count_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (statusReg[12:2] == 11'd0) && !memWrEn);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    32'(statusReg[12:2]) <= MAXQ);

  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxError || hostWrErr) |=> statusReg[31]);
endmodule

bind sid_tracker sid_tracker_chk #(.ALIGN_LSB(ALIGN_LSB)) u_chk (
  .clk(clk), .rstN(rstN), .busReset(busReset), .rxError(rxError),
  .hostWrErr(hostWrErr), .ptrReg(ptrReg), .statusReg(statusReg),
  .memWrEn(memWrEn), .memWrAddr(memWrAddr)
);

// File: tb/sid_tracker_tb.sv
`timescale 1ns/1ps
module sid_tracker_tb;
  localparam int ALIGN = 6;
  localparam int MAXQ  = 1 << (ALIGN - 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 0, qValid = 0, rxError = 0, rxDone = 0, hostWrErr = 0;
  logic regWrEn = 0, regWrSel = 0;
  logic [31:0] qData = '0, regWrData = '0;
  logic [31:0] ptrReg, statusReg, memWrAddr, memWrData;
  logic memWrEn;

  int errors = 0;
  int checks = 0;
  int expGen = 0;
  int expCnt = 0;
  bit expErr = 0;
  logic [31:0] expPtr = '0;

  always #5 clk = ~clk;

  sid_tracker #(.ALIGN_LSB(ALIGN)) u_dut (
    .clk(clk), .rstN(rstN), .busReset(busReset), .qValid(qValid),
    .qData(qData), .rxError(rxError), .rxDone(rxDone), .hostWrErr(hostWrErr),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .ptrReg(ptrReg), .statusReg(statusReg), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus();
    return {expErr, 7'd0, 8'(expGen), 3'd0, 11'(expCnt), 2'd0};
  endfunction

  task automatic pulseReset();
    busReset = 1; @(negedge clk); busReset = 0;
    expGen = (expGen + 1) % 256; expCnt = 0;
  endtask

  task automatic sendQ(input logic [31:0] d, input bit expectWrite, input string req);
    logic [31:0] a;
    a = expPtr + 32'(expCnt * 4);
    qValid = 1; qData = d; @(negedge clk); qValid = 0;
    chk({req, " memWrEn"}, {31'd0, memWrEn}, {31'd0, expectWrite});
    if (expectWrite) begin
      chk({req, " addr"}, memWrAddr, a);
      chk({req, " data"}, memWrData, d);
      expCnt++;
    end
  endtask

  task automatic t_reset();
    chk("R1 ptr", ptrReg, 32'd0);
    chk("R1 status", statusReg, 32'd0);
    chk("R1 memWrEn", {31'd0, memWrEn}, 32'd0);
  endtask

  task automatic t_regs();
    regWrEn = 1; regWrSel = 0; regWrData = 32'hDEAD_BEEF;
    @(negedge clk); regWrEn = 0;
    expPtr = 32'hDEAD_BEC0;
    chk("R2 ptr masked", ptrReg, expPtr);
    regWrEn = 1; regWrSel = 1; regWrData = 32'hFFFF_FFFF;
    @(negedge clk); regWrEn = 0;
    chk("R10 status unchanged", statusReg, expStatus());
    chk("R10 ptr unchanged", ptrReg, expPtr);
  endtask

  task automatic t_frame();
    pulseReset();
    chk("R5 gen after reset", statusReg, expStatus());
    sendQ(32'h1111_0001, 1, "R4 q0");
    sendQ(32'h2222_0002, 1, "R4 q1");
    sendQ(32'h3333_0003, 1, "R4 q2");
    chk("R3 status layout", statusReg, expStatus());
  endtask

  task automatic t_collide();
    busReset = 1; qValid = 1; qData = 32'hBAD0_0000;
    @(negedge clk); busReset = 0; qValid = 0;
    expGen = (expGen + 1) % 256; expCnt = 0;
    chk("R6 dropped write", {31'd0, memWrEn}, 32'd0);
    chk("R6 count cleared", statusReg, expStatus());
  endtask

  task automatic t_sat();
    pulseReset();
    for (int i = 0; i < MAXQ; i++) sendQ(32'hA000_0000 + 32'(i), 1, "R7 fill");
    chk("R7 count at limit", statusReg, expStatus());
    sendQ(32'hFFFF_0000, 0, "R7 over");
    chk("R7 count held", statusReg, expStatus());
  endtask

  task automatic t_err();
    rxError = 1; @(negedge clk); rxError = 0; expErr = 1;
    chk("R8 rxError sets", statusReg, expStatus());
    rxDone = 1; @(negedge clk); rxDone = 0;
    chk("R9 bad reception keeps flag", statusReg, expStatus());
    pulseReset();
    sendQ(32'h5555_AAAA, 1, "R4 clean q");
    rxDone = 1; @(negedge clk); rxDone = 0; expErr = 0;
    chk("R9 clean reception clears", statusReg, expStatus());
    hostWrErr = 1; @(negedge clk); hostWrErr = 0; expErr = 1;
    chk("R8 hostWrErr sets", statusReg, expStatus());
    rxDone = 1; @(negedge clk); rxDone = 0;
    chk("R9 flag kept", statusReg, expStatus());
    rxDone = 1; @(negedge clk); rxDone = 0; expErr = 0;
    chk("R9 next clean done clears", statusReg, expStatus());
  endtask

  task automatic t_wrap();
    bit sawWrap = 0;
    for (int i = 0; i < 256; i++) begin
      pulseReset();
      if (expGen == 0) begin
        sawWrap = 1;
        chk("R5 wrap to zero", {24'd0, statusReg[23:16]}, 32'd0);
      end
    end
    chk("R5 wrap seen", {31'd0, sawWrap}, 32'd1);
    chk("R5 full cycle", statusReg, expStatus());
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_frame();
    t_collide();
    t_sat();
    t_err();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule